// File: doc/BRIEF.md
# Privilege Context Layout Parser

This block turns a short ASCII description of processor cores into a numbered table of interrupt contexts. The description is a list of groups separated by commas. Each group names the privilege modes one core exposes, using the letters `U` (user), `S` (supervisor) and `M` (machine). A string such as `M,MS,MS` describes three cores: the first has one context and the other two have two contexts each. Every mode letter becomes a new context. Contexts are numbered from zero in the order the letters arrive.

Characters arrive one per handshake beat, using valid/ready. The string is closed by a separate end beat, whose character field is not used. While the string is parsed, the core identifier for each context is formed as a base identifier plus the index of the non-empty group the letter belongs to. Empty groups, produced by leading, doubled or trailing commas, do not consume a core index.

When the end beat is accepted, the parser reports the context count and the core count and raises `done`. A bad character, a repeated mode within one group, or more letters than the table can hold stops the parser with a sticky error and an error code. After either outcome the parser accepts nothing more until reset. The table can be read at any time through an index port.

Top module: `ctx_cfg_parser`

## Requirements
- R1: After reset, `in_ready` is 1, while `done`, `error`, `err_kind`, `ctx_count` and `core_count` are all 0.
- R2: Each accepted letter `U`, `S` or `M` writes the next free table entry, in arrival order. The entry's mode code is 0 for `U`, 1 for `S` and 3 for `M`, and `ctx_count` rises by exactly one.
- R3: The core identifier stored with an entry equals `base_core` plus the number of non-empty groups completed before the letter, modulo 2^CORE_W.
- R4: A comma, or the end beat, adds one to `core_count` only when the group it closes holds at least one letter. Empty groups leave `core_count` unchanged.
- R5: One cycle after the end beat is accepted, `done` is 1 and `in_ready` is 0. `ctx_count` then equals the number of letters and `core_count` the number of non-empty groups. `core_count` never exceeds `ctx_count`.
- R6: Any character other than `U`, `S`, `M` or comma stops the parse with `error`=1 and `err_kind`=1.
- R7: A letter already seen in the current group stops the parse with `err_kind`=2. The same letter in different groups is legal.
- R8: A letter arriving when MAX_CTX entries are already filled stops the parse with `err_kind`=3. Exactly MAX_CTX letters complete normally.
- R9: Once `error` is 1, it stays 1 until reset. `done` and `in_ready` stay 0, and the counts do not change.
- R10: While `done` is 1, it stays 1, `in_ready` is 0, and the counts and table contents do not change.
- R11: `rd_valid` is 1 exactly when `rd_idx` is less than `ctx_count`. `rd_core` and `rd_mode` show the entry at `rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Character beat is offered |
| in_ready | output | 1 | Parser accepts a beat this cycle |
| in_char | input | 8 | ASCII character of the beat |
| in_end | input | 1 | Beat is the end-of-string marker (character ignored) |
| base_core | input | CORE_W | Identifier of the first core; held stable during a parse |
| rd_idx | input | IDX_W | Table entry to read |
| rd_valid | output | 1 | Entry at `rd_idx` has been written |
| rd_core | output | CORE_W | Core identifier of the entry |
| rd_mode | output | 2 | Mode code of the entry (0 user, 1 supervisor, 3 machine) |
| ctx_count | output | CNT_W | Contexts created so far |
| core_count | output | CNT_W | Non-empty groups closed so far |
| done | output | 1 | String parsed without error |
| error | output | 1 | Parse stopped on an error |
| err_kind | output | 2 | 0 none, 1 bad character, 2 duplicate mode, 3 table full |

## Verification
The table-full error is the hardest case to reach, because it needs a long, otherwise legal string. Every group must avoid repeating a letter, so the bench builds strings of three-letter groups. One such string ends exactly at MAX_CTX letters and another adds one letter more. All strings of up to four characters over `U`, `S`, `M`, comma and one illegal character are swept with varying base identifiers. This covers empty groups, duplicates and bad characters at every position, as well as base identifiers that wrap around. After each outcome, further beats are offered to confirm they are ignored.

// File: rtl/ctx_cfg_pkg.sv
package ctx_cfg_pkg;

    typedef enum logic [1:0] {
        MODE_USER = 2'd0,
        MODE_SUPV = 2'd1,
        MODE_MACH = 2'd3
    } priv_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PARSE = 2'd1,
        ST_DONE  = 2'd2,
        ST_ERROR = 2'd3
    } pstate_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_BADCHAR = 2'd1,
        ERR_DUPMODE = 2'd2,
        ERR_FULL    = 2'd3
    } perr_e;

endpackage

// File: rtl/ctx_char_decode.sv
module ctx_char_decode
    import ctx_cfg_pkg::*;
(
    input  logic [7:0] ch,
    output logic       is_sep,
    output logic       is_mode,
    output priv_mode_e mode,
    output logic [2:0] mode_oh
);
    always_comb begin
        is_sep  = 1'b0;
        is_mode = 1'b0;
        mode    = MODE_USER;
        mode_oh = 3'b000;
        case (ch)
            8'h2C: is_sep = 1'b1;
            8'h55: begin is_mode = 1'b1; mode = MODE_USER; mode_oh = 3'b001; end
            8'h53: begin is_mode = 1'b1; mode = MODE_SUPV; mode_oh = 3'b010; end
            8'h4D: begin is_mode = 1'b1; mode = MODE_MACH; mode_oh = 3'b100; end
            default: ;
        endcase
    end
endmodule

// File: rtl/ctx_table.sv
module ctx_table
    import ctx_cfg_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CORE_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [CORE_W-1:0] wr_core,
    input  priv_mode_e        wr_mode,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CORE_W-1:0] rd_core,
    output priv_mode_e        rd_mode
);
    logic [CORE_W-1:0] core_q [DEPTH];
    priv_mode_e        mode_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                core_q[g] <= '0;
                mode_q[g] <= MODE_USER;
            end else if (hit) begin
                core_q[g] <= wr_core;
                mode_q[g] <= wr_mode;
            end
        end
    end

    assign rd_core = core_q[rd_idx];
    assign rd_mode = mode_q[rd_idx];
endmodule

// File: rtl/ctx_cfg_parser.sv
module ctx_cfg_parser
    import ctx_cfg_pkg::*;
#(
    parameter int MAX_CTX = 16,
    parameter int CORE_W  = 8,
    localparam int IDX_W  = $clog2(MAX_CTX),
    localparam int CNT_W  = $clog2(MAX_CTX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_char,
    input  logic              in_end,
    input  logic [CORE_W-1:0] base_core,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [CORE_W-1:0] rd_core,
    output logic [1:0]        rd_mode,
    output logic [CNT_W-1:0]  ctx_count,
    output logic [CNT_W-1:0]  core_count,
    output logic              done,
    output logic              error,
    output logic [1:0]        err_kind
);
    typedef struct packed {
        pstate_e          st;
        logic [CNT_W-1:0] nctx;
        logic [CNT_W-1:0] ncore;
        logic [2:0]       seen;
        perr_e            err;
    } pstate_t;

    pstate_t s_d, s_q;

    logic       is_sep, is_mode;
    priv_mode_e dec_mode;
    logic [2:0] dec_oh;
    logic       accept, wr_en;
    priv_mode_e tbl_mode;

    ctx_char_decode u_dec (
        .ch      (in_char),
        .is_sep  (is_sep),
        .is_mode (is_mode),
        .mode    (dec_mode),
        .mode_oh (dec_oh)
    );

    assign in_ready = (s_q.st == ST_IDLE) || (s_q.st == ST_PARSE);
    assign accept   = in_valid && in_ready;

    always_comb begin
        s_d   = s_q;
        wr_en = 1'b0;
        if (accept) begin
            s_d.st = ST_PARSE;
            if (in_end || is_sep) begin
                if (s_q.seen != 3'b000) s_d.ncore = s_q.ncore + 1'b1;
                s_d.seen = 3'b000;
                if (in_end) s_d.st = ST_DONE;
            end else if (is_mode) begin
                if ((s_q.seen & dec_oh) != 3'b000) begin
                    s_d.st  = ST_ERROR;
                    s_d.err = ERR_DUPMODE;
                end else if (s_q.nctx == CNT_W'(MAX_CTX)) begin
                    s_d.st  = ST_ERROR;
                    s_d.err = ERR_FULL;
                end else begin
                    wr_en     = 1'b1;
                    s_d.nctx  = s_q.nctx + 1'b1;
                    s_d.seen  = s_q.seen | dec_oh;
                end
            end else begin
                s_d.st  = ST_ERROR;
                s_d.err = ERR_BADCHAR;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, nctx: '0, ncore: '0, seen: 3'b000, err: ERR_NONE};
        end else begin
            s_q <= s_d;
        end
    end

    ctx_table #(.DEPTH(MAX_CTX), .CORE_W(CORE_W)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (s_q.nctx[IDX_W-1:0]),
        .wr_core (base_core + CORE_W'(s_q.ncore)),
        .wr_mode (dec_mode),
        .rd_idx  (rd_idx),
        .rd_core (rd_core),
        .rd_mode (tbl_mode)
    );

    assign rd_mode    = tbl_mode;
    assign rd_valid   = CNT_W'(rd_idx) < s_q.nctx;
    assign ctx_count  = s_q.nctx;
    assign core_count = s_q.ncore;
    assign done       = (s_q.st == ST_DONE);
    assign error      = (s_q.st == ST_ERROR);
    assign err_kind   = s_q.err;

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && !in_ready && $stable(ctx_count) && $stable(core_count));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error && !done && !in_ready && $stable(ctx_count) && $stable(err_kind));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_count <= CNT_W'(MAX_CTX));

    // R5
    core_le_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_count <= ctx_count);

    // R2
    ctx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=>
            (ctx_count == $past(ctx_count)) || (ctx_count == $past(ctx_count) + 1'b1));

    // R6
    err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error == (err_kind != 2'd0));
endmodule

// File: tb/ctx_cfg_parser_bench.sv
`timescale 1ns/1ps
module ctx_cfg_parser_bench;
    localparam int MAXC = 16;
    localparam int CW   = 8;
    localparam int IW   = $clog2(MAXC);
    localparam int NW   = $clog2(MAXC + 1);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, in_valid, in_ready, in_end, rd_valid, done, error;
    logic [7:0]    in_char;
    logic [CW-1:0] base_core, rd_core;
    logic [IW-1:0] rd_idx;
    logic [1:0]    rd_mode, err_kind;
    logic [NW-1:0] ctx_count, core_count;

    ctx_cfg_parser #(.MAX_CTX(MAXC), .CORE_W(CW)) u_ctx_cfg_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_char(in_char), .in_end(in_end), .base_core(base_core),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_core(rd_core), .rd_mode(rd_mode),
        .ctx_count(ctx_count), .core_count(core_count), .done(done),
        .error(error), .err_kind(err_kind)
    );

    int n_chk = 0;
    int n_err = 0;
    byte str [0:63];
    int  slen;
    int  e_ctx, e_core, e_err;
    bit  e_done;
    int  e_mode [0:MAXC-1];
    int  e_cid  [0:MAXC-1];

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model(input int base);
        int seen;
        seen = 0; e_ctx = 0; e_core = 0; e_err = 0; e_done = 0;
        for (int i = 0; i < slen; i++) begin
            byte c;
            int b, m;
            c = str[i];
            if (c == ",") begin
                if (seen != 0) e_core++;
                seen = 0;
            end else if (c == "U" || c == "S" || c == "M") begin
                b = (c == "U") ? 1 : (c == "S") ? 2 : 4;
                m = (c == "U") ? 0 : (c == "S") ? 1 : 3;
                if ((seen & b) != 0) begin e_err = 2; return; end
                if (e_ctx == MAXC) begin e_err = 3; return; end
                e_mode[e_ctx] = m;
                e_cid[e_ctx]  = (base + e_core) % 256;
                e_ctx++;
                seen = seen | b;
            end else begin
                e_err = 1;
                return;
            end
        end
        if (seen != 0) e_core++;
        e_done = 1;
    endtask

    task automatic run(input int base);
        string etag;
        rst_n = 1'b0; in_valid = 1'b0; in_end = 1'b0; in_char = 8'h0;
        base_core = CW'(base); rd_idx = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", int'(in_ready), 1);
        chk("R1 done/error", int'({done, error, err_kind}), 0);
        chk("R1 counts", int'(ctx_count) + int'(core_count), 0);
        model(base);
        for (int i = 0; i <= slen; i++) begin
            if (i > 0) @(negedge clk);
            in_valid = 1'b0;
            if (!in_ready) break;
            in_valid = 1'b1;
            in_char  = (i < slen) ? str[i] : 8'h00;
            in_end   = (i == slen);
        end
        @(negedge clk);
        in_valid = 1'b0; in_end = 1'b0;
        etag = (e_err == 1) ? "R6 err_kind" : (e_err == 2) ? "R7 err_kind" :
               (e_err == 3) ? "R8 err_kind" : "R5 err_kind";
        chk(etag, int'(err_kind), e_err);
        chk("R5 done", int'(done), int'(e_done));
        chk("R9 error", int'(error), (e_err != 0) ? 1 : 0);
        chk("R5 ready low", int'(in_ready), 0);
        chk("R2 ctx_count", int'(ctx_count), e_ctx);
        chk("R4 core_count", int'(core_count), e_core);
        for (int j = 0; j < e_ctx; j++) begin
            rd_idx = IW'(j);
            #0.5;
            chk("R2 mode", int'(rd_mode), e_mode[j]);
            chk("R3 core id", int'(rd_core), e_cid[j]);
            chk("R11 rd_valid set", int'(rd_valid), 1);
        end
        if (e_ctx < MAXC) begin
            rd_idx = IW'(e_ctx);
            #0.5;
            chk("R11 rd_valid clear", int'(rd_valid), 0);
        end
        // R9 R10 later beats ignored
        in_valid = 1'b1; in_char = "U";
        repeat (3) @(negedge clk);
        in_end = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_end = 1'b0;
        chk(e_done ? "R10 ctx hold" : "R9 ctx hold", int'(ctx_count), e_ctx);
        chk(e_done ? "R10 core hold" : "R9 core hold", int'(core_count), e_core);
        chk(e_done ? "R10 done hold" : "R9 done low", int'(done), int'(e_done));
        if (e_ctx > 0) begin
            rd_idx = IW'(e_ctx - 1);
            #0.5;
            chk(e_done ? "R10 table hold" : "R9 table hold", int'(rd_mode), e_mode[e_ctx - 1]);
        end
    endtask

    task automatic build_groups(input int letters, input bit tail_comma);
        int n;
        slen = 0; n = 0;
        while (n < letters) begin
            if (n > 0 && (n % 3) == 0) begin str[slen] = ","; slen++; end
            str[slen] = (n % 3 == 0) ? "M" : (n % 3 == 1) ? "S" : "U";
            slen++; n++;
        end
        if (tail_comma) begin str[slen] = ","; slen++; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R5 actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        byte alpha [0:4];
        alpha[0] = "U"; alpha[1] = "S"; alpha[2] = "M"; alpha[3] = ","; alpha[4] = "x";
        for (int len = 0; len <= 4; len++) begin
            int total;
            total = 1;
            for (int p = 0; p < len; p++) total = total * 5;
            for (int k = 0; k < total; k++) begin
                int v;
                v = k;
                for (int p = 0; p < len; p++) begin
                    str[p] = alpha[v % 5];
                    v = v / 5;
                end
                slen = len;
                run((k * 37 + len * 11 + 250) % 256);
            end
        end
        // R8 exact fill completes, one more letter overflows
        build_groups(MAXC, 1'b0);      run(3);
        build_groups(MAXC, 1'b1);      run(254);
        build_groups(MAXC + 1, 1'b0);  run(7);
        // R4 empty groups skipped around letters
        str[0] = ","; str[1] = ","; str[2] = "M"; str[3] = ","; str[4] = ",";
        str[5] = "S"; str[6] = "U"; str[7] = ","; slen = 8;
        run(100);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule